// File: doc/BRIEF.md
# Late-Write Synchronous SRAM Core

This block is a synchronous static RAM whose write data trails its command by one clock. The address, the select, the write enable and the four lane enables are all sampled together on a rising edge. For a write, the data word is taken on the following edge. For a read, the word is loaded into an output register on the following edge and presented from there. The word is 36 bits wide and is split into four 9-bit byte lanes. The depth is a small parameter.

The write data arrives late, so the core keeps the most recent write in a pending buffer. That write reaches the array only when the data of the next write arrives, which leaves the array port free for reads in between. A read whose address matches the pending write, or matches an entry being moved into the array on the same edge, gets those bytes forwarded into its result lane by lane.

An active-low output enable and an active-high sleep input act on the outputs without waiting for the clock. The data outputs are modelled as a value plus a drive-enable flag, and the flag shows bus direction for read/write turnaround. While sleep is high, new commands are dropped and the stored contents are kept.

Top module: `lw_sram_core`

## Requirements
- R1: While `rst` is high and after it is released, with no read yet issued, `dq_oe_o` is 0 and `dq_o` is 0.
- R2: A read (`cs_i`=1, `we_i`=0) sampled at edge N makes `dq_oe_o`=1 and `dq_o` equal the addressed word from edge N+1 to edge N+2 (`oe_n_i`=0, `sleep_i`=0). If the command at edge N+1 is not a read, including a write, `dq_oe_o` returns to 0 after edge N+2.
- R3: The write data for a write sampled at edge N is the value on `wdata_i` at edge N+1. The value on `wdata_i` at edge N itself is not used.
- R4: Lane enable `be_i[k]` selects bits [9k+8:9k] of the word. A write with mask 4'b1111 replaces the whole word, and a mask of 4'b0000 leaves the stored word unchanged.
- R5: A read returns the latest write to its address in these cases: the write is still pending, the write was only partly masked, or the write is being moved into the array on the same edge as the read's command.
- R6: With `cs_i`=0 the command is ignored, `we_i` included, and `dq_oe_o` is 0 in the cycle after the next edge.
- R7: `oe_n_i`=1 forces `dq_oe_o` to 0 at once, with no clock edge needed. Returning it to 0 restores the drive of a valid output word.
- R8: While `sleep_i`=1, commands are ignored and `dq_oe_o` is 0. The memory contents are kept, and a read on the first edge after `sleep_i` falls is served normally.
- R9: `dq_o` is all zeros whenever `dq_oe_o` is 0.
- R10: A pending write is moved into the array when the data of the next write arrives. Earlier writes stay readable after later writes to other addresses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cs_i | input | 1 | Synchronous select, active high |
| we_i | input | 1 | Write command when 1, read when 0 |
| be_i | input | LANES | Per-lane write enables |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | LANES*LANE_W | Write data, one cycle after its command |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| sleep_i | input | 1 | Asynchronous sleep request, active high |
| dq_o | output | LANES*LANE_W | Read data, zero when not driven |
| dq_oe_o | output | 1 | High while the core drives the data bus |

## Verification
On every cycle the assertions check the following:
- no drive after reset, after a deselect or during sleep;
- drive following a read command;
- the late capture of write data into the pending buffer;
- forwarding of a fully masked pending write into the output register.

Only the directed scenarios can show that data values are correct after they have passed through the array:
- partial lane merges;
- the forward from an entry being moved into the array on the same edge;
- that ignored commands left memory untouched;
- the asynchronous effect of the output enable and sleep inside a single cycle.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;
  // command held in the capture stage
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/lw_cmd_stage.sv
module lw_cmd_stage
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_i,
  input  logic              we_i,
  input  logic              sleep_i,
  input  logic [LANES-1:0]  be_i,
  input  logic [ADDR_W-1:0] addr_i,
  output op_e               op_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [LANES-1:0]  be_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      op_q   <= OP_IDLE;
      addr_q <= '0;
      be_q   <= '0;
    end else begin
      addr_q <= addr_i;
      be_q   <= be_i;
      if (sleep_i || !cs_i) op_q <= OP_IDLE;
      else if (we_i)        op_q <= OP_WRITE;
      else                  op_q <= OP_READ;
    end
  end
endmodule

// File: rtl/lw_pend_buf.sv
module lw_pend_buf
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  op_e                     op_q,
  input  logic [ADDR_W-1:0]       addr_q,
  input  logic [LANES-1:0]        be_q,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  output logic                    pend_vld,
  output logic [ADDR_W-1:0]       pend_addr,
  output logic [LANES-1:0]        pend_be,
  output logic [LANES*LANE_W-1:0] pend_data,
  output logic [LANES-1:0]        cm_mask,
  output logic [ADDR_W-1:0]       cm_addr,
  output logic [LANES*LANE_W-1:0] cm_data,
  output logic                    cmq_vld,
  output logic [ADDR_W-1:0]       cmq_addr,
  output logic [LANES-1:0]        cmq_be,
  output logic [LANES*LANE_W-1:0] cmq_data
);
  logic data_edge;
  logic cm_en;

  // the data of a write captured one edge earlier is on wdata_i now
  assign data_edge = (op_q == OP_WRITE);
  // the older pending entry drains into the array as the new one arrives
  assign cm_en   = data_edge && pend_vld;
  assign cm_mask = cm_en ? pend_be : '0;
  assign cm_addr = pend_addr;
  assign cm_data = pend_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_vld  <= 1'b0;
      pend_addr <= '0;
      pend_be   <= '0;
      pend_data <= '0;
    end else if (data_edge) begin
      pend_vld  <= 1'b1;
      pend_addr <= addr_q;
      pend_be   <= be_q;
      pend_data <= wdata_i;
    end
  end

  // snapshot of the entry drained this edge, for a read-first array hit
  always_ff @(posedge clk) begin
    if (rst) begin
      cmq_vld  <= 1'b0;
      cmq_addr <= '0;
      cmq_be   <= '0;
      cmq_data <= '0;
    end else begin
      cmq_vld  <= cm_en;
      cmq_addr <= pend_addr;
      cmq_be   <= pend_be;
      cmq_data <= pend_data;
    end
  end

  // R3
  late_data_chk: assert property (@(posedge clk) disable iff (rst)
    (op_q == OP_WRITE) |=> (pend_vld && pend_data == $past(wdata_i)));
endmodule

// File: rtl/lw_lane_array.sv
module lw_lane_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rd_en,
  input  logic [ADDR_W-1:0]       rd_addr,
  input  logic [LANES-1:0]        wr_mask,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LANES*LANE_W-1:0] wr_data,
  output logic [LANES*LANE_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_q;

    // read-first single-clock RAM, one per lane
    always_ff @(posedge clk) begin
      if (wr_mask[l]) mem[wr_addr] <= wr_data[l*LANE_W +: LANE_W];
      if (rd_en)      rd_q <= mem[rd_addr];
    end

    assign rd_data[l*LANE_W +: LANE_W] = rd_q;
  end
endmodule

// File: rtl/lw_out_stage.sv
module lw_out_stage
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  op_e                     op_q_i,
  input  logic [ADDR_W-1:0]       addr_q_i,
  input  logic [LANES*LANE_W-1:0] raw_i,
  input  logic                    cmq_vld_i,
  input  logic [ADDR_W-1:0]       cmq_addr_i,
  input  logic [LANES-1:0]        cmq_be_i,
  input  logic [LANES*LANE_W-1:0] cmq_data_i,
  input  logic                    pend_vld_i,
  input  logic [ADDR_W-1:0]       pend_addr_i,
  input  logic [LANES-1:0]        pend_be_i,
  input  logic [LANES*LANE_W-1:0] pend_data_i,
  input  logic                    oe_n_i,
  input  logic                    sleep_i,
  output logic [LANES*LANE_W-1:0] dq_o,
  output logic                    dq_oe_o
);
  logic                    cmq_hit, pend_hit;
  logic [LANES*LANE_W-1:0] merged;
  logic [LANES*LANE_W-1:0] out_q;
  logic                    out_vld;
  logic                    drive;

  assign cmq_hit  = cmq_vld_i  && (cmq_addr_i  == addr_q_i);
  assign pend_hit = pend_vld_i && (pend_addr_i == addr_q_i);

  // newest source wins per lane: pending, then drained entry, then array
  for (genvar l = 0; l < LANES; l++) begin : g_merge
    assign merged[l*LANE_W +: LANE_W] =
      (pend_hit && pend_be_i[l]) ? pend_data_i[l*LANE_W +: LANE_W] :
      (cmq_hit  && cmq_be_i[l])  ? cmq_data_i[l*LANE_W +: LANE_W]  :
                                   raw_i[l*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      out_q   <= '0;
    end else begin
      out_vld <= (op_q_i == OP_READ);
      if (op_q_i == OP_READ) out_q <= merged;
    end
  end

  assign drive   = out_vld && !oe_n_i && !sleep_i;
  assign dq_oe_o = drive;
  assign dq_o    = drive ? out_q : '0;

  // R5
  fwd_pending_chk: assert property (@(posedge clk) disable iff (rst)
    (op_q_i == OP_READ && pend_vld_i && pend_addr_i == addr_q_i && (&pend_be_i))
    |=> (out_q == $past(pend_data_i)));
endmodule

// File: rtl/lw_sram_core.sv
module lw_sram_core
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cs_i,
  input  logic                    we_i,
  input  logic [LANES-1:0]        be_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  input  logic                    oe_n_i,
  input  logic                    sleep_i,
  output logic [LANES*LANE_W-1:0] dq_o,
  output logic                    dq_oe_o
);
  localparam int WORD_W = LANES * LANE_W;

  op_e               op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LANES-1:0]  be_q;
  logic              rd_now;

  logic              pend_vld, cmq_vld;
  logic [ADDR_W-1:0] pend_addr, cm_addr, cmq_addr;
  logic [LANES-1:0]  pend_be, cm_mask, cmq_be;
  logic [WORD_W-1:0] pend_data, cm_data, cmq_data, raw_data;

  assign rd_now = cs_i && !we_i && !sleep_i;

  lw_cmd_stage #(.ADDR_W(ADDR_W), .LANES(LANES)) u_cmd (
    .clk(clk), .rst(rst), .cs_i(cs_i), .we_i(we_i), .sleep_i(sleep_i),
    .be_i(be_i), .addr_i(addr_i),
    .op_q(op_q), .addr_q(addr_q), .be_q(be_q)
  );

  lw_pend_buf #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_pend (
    .clk(clk), .rst(rst), .op_q(op_q), .addr_q(addr_q), .be_q(be_q),
    .wdata_i(wdata_i),
    .pend_vld(pend_vld), .pend_addr(pend_addr), .pend_be(pend_be),
    .pend_data(pend_data),
    .cm_mask(cm_mask), .cm_addr(cm_addr), .cm_data(cm_data),
    .cmq_vld(cmq_vld), .cmq_addr(cmq_addr), .cmq_be(cmq_be),
    .cmq_data(cmq_data)
  );

  lw_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk(clk), .rd_en(rd_now), .rd_addr(addr_i),
    .wr_mask(cm_mask), .wr_addr(cm_addr), .wr_data(cm_data),
    .rd_data(raw_data)
  );

  lw_out_stage #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_out (
    .clk(clk), .rst(rst), .op_q_i(op_q), .addr_q_i(addr_q), .raw_i(raw_data),
    .cmq_vld_i(cmq_vld), .cmq_addr_i(cmq_addr), .cmq_be_i(cmq_be),
    .cmq_data_i(cmq_data),
    .pend_vld_i(pend_vld), .pend_addr_i(pend_addr), .pend_be_i(pend_be),
    .pend_data_i(pend_data),
    .oe_n_i(oe_n_i), .sleep_i(sleep_i),
    .dq_o(dq_o), .dq_oe_o(dq_oe_o)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> !dq_oe_o);

  // R2
  read_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_i && !we_i && !sleep_i) |=> ##1 (dq_oe_o || oe_n_i || sleep_i));

  // R6
  desel_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !cs_i |=> ##1 !dq_oe_o);

  // R8
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    sleep_i |=> ##1 !dq_oe_o);
endmodule

// File: tb/lw_sram_core_tb_top.sv
module lw_sram_core_tb_top;
  localparam int AW = 6;
  localparam int LN = 4;
  localparam int LW = 9;
  localparam int W  = LN * LW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cs_i = 1'b0, we_i = 1'b0, oe_n_i = 1'b0, sleep_i = 1'b0;
  logic [LN-1:0] be_i = '0;
  logic [AW-1:0] addr_i = '0;
  logic [W-1:0]  wdata_i = '0;
  logic [W-1:0]  dq_o;
  logic          dq_oe_o;

  int total = 0;
  int bad   = 0;
  logic [W-1:0] nxt_wd = '0;
  logic         slp = 1'b0;
  logic [W-1:0] shadow [1 << AW];

  always #4 clk = ~clk;

  lw_sram_core #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) dut_i (
    .clk(clk), .rst(rst), .cs_i(cs_i), .we_i(we_i), .be_i(be_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .oe_n_i(oe_n_i), .sleep_i(sleep_i),
    .dq_o(dq_o), .dq_oe_o(dq_oe_o)
  );

  function automatic logic [W-1:0] mrg(logic [W-1:0] old, logic [W-1:0] nw,
                                       logic [LN-1:0] be);
    logic [W-1:0] r = old;
    for (int k = 0; k < LN; k++)
      if (be[k]) r[k*LW +: LW] = nw[k*LW +: LW];
    return r;
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one command per cycle; the write data of the previous command goes out here
  task automatic tick(logic cs, logic we, logic [LN-1:0] be, logic [AW-1:0] a,
                      logic [W-1:0] d);
    @(posedge clk);
    #1;
    wdata_i = nxt_wd;
    cs_i = cs; we_i = we; be_i = be; addr_i = a; sleep_i = slp;
    nxt_wd = d;
  endtask

  task automatic idle();
    tick(1'b0, 1'b0, '0, '0, '0);
  endtask

  task automatic wr(logic [AW-1:0] a, logic [LN-1:0] be, logic [W-1:0] d);
    tick(1'b1, 1'b1, be, a, d);
    shadow[a] = mrg(shadow[a], d, be);
  endtask

  task automatic rd(logic [AW-1:0] a);
    tick(1'b1, 1'b0, '0, a, '0);
  endtask

  task automatic peek(string req, logic exp_oe, logic [W-1:0] exp_dq);
    #2;
    check({req, " drive"}, {{(W-1){1'b0}}, dq_oe_o}, {{(W-1){1'b0}}, exp_oe});
    check({req, " data"}, dq_o, exp_oe ? exp_dq : '0);
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    peek("R1 after reset", 1'b0, '0);
    idle();
    peek("R1 idle after reset", 1'b0, '0);
  endtask

  task automatic t_basic();
    wr(6'd3, 4'hF, 36'h1_2345_6789);
    rd(6'd3);
    idle(); idle();
    peek("R2 R3 read after write", 1'b1, shadow[3]);
    idle();
    peek("R2 single cycle drive", 1'b0, '0);
  endtask

  task automatic t_commit();
    wr(6'd5, 4'hF, 36'hA_BCDE_F012);
    wr(6'd6, 4'hF, 36'h3_0303_0303);
    idle();
    rd(6'd5); rd(6'd6);
    idle();
    peek("R10 array word after later write", 1'b1, shadow[5]);
    idle();
    peek("R10 pending word", 1'b1, shadow[6]);
  endtask

  task automatic t_bypass();
    wr(6'd7, 4'hF, 36'h7_7777_0000);
    rd(6'd7);
    idle(); idle();
    peek("R5 back-to-back forward", 1'b1, shadow[7]);
    wr(6'd9, 4'hF, 36'h9_1111_2222);
    wr(6'd10, 4'hF, 36'h1_0101_0101);
    rd(6'd9);
    idle(); idle();
    peek("R5 hit on draining entry", 1'b1, shadow[9]);
    wr(6'd5, 4'b0101, 36'hF_FFFF_FFFF);
    rd(6'd5);
    idle(); idle();
    peek("R5 partial forward", 1'b1, shadow[5]);
  endtask

  task automatic t_lanes();
    wr(6'd11, 4'hF, 36'h0_1234_5678);
    wr(6'd11, 4'b1000, 36'hE_EEEE_EEEE);
    wr(6'd6, 4'b0000, 36'h5_5555_5555);
    wr(6'd13, 4'hF, 36'hD_0000_000D);
    idle();
    rd(6'd11); rd(6'd6);
    idle();
    peek("R4 top lane only", 1'b1, shadow[11]);
    idle();
    peek("R4 empty mask", 1'b1, 36'h3_0303_0303);
  endtask

  task automatic t_desel();
    rd(6'd3);
    tick(1'b0, 1'b1, 4'hF, 6'd6, 36'hB_AD00_0BAD);
    idle();
    peek("R6 read before deselect", 1'b1, shadow[3]);
    idle();
    peek("R6 no drive after deselect", 1'b0, '0);
    rd(6'd6);
    idle(); idle();
    peek("R6 deselected write ignored", 1'b1, shadow[6]);
  endtask

  task automatic t_oe();
    rd(6'd3);
    idle(); idle();
    peek("R7 driven before disable", 1'b1, shadow[3]);
    #1 oe_n_i = 1'b1;
    #1 check("R7 async disable", {35'b0, dq_oe_o}, '0);
    check("R9 zero when undriven", dq_o, '0);
    oe_n_i = 1'b0;
    #1 check("R7 async re-enable", dq_o, shadow[3]);
  endtask

  task automatic t_sleep();
    idle();
    slp = 1'b1;
    tick(1'b1, 1'b1, 4'hF, 6'd3, 36'h0_DEAD_BEEF);
    rd(6'd3);
    idle();
    peek("R8 no drive while asleep", 1'b0, '0);
    idle();
    slp = 1'b0;
    rd(6'd3);
    idle(); idle();
    peek("R8 contents kept, resumes", 1'b1, shadow[3]);
    rd(6'd3);
    idle(); idle();
    #1 sleep_i = 1'b1;
    #1 check("R8 async sleep quiets bus", {35'b0, dq_oe_o}, '0);
    sleep_i = 1'b0;
  endtask

  task automatic t_turn();
    rd(6'd3);
    wr(6'd14, 4'hF, 36'h1_4141_4141);
    idle();
    peek("R2 read drive before turnaround", 1'b1, shadow[3]);
    idle();
    peek("R2 released for write", 1'b0, '0);
    rd(6'd14);
    idle(); idle();
    peek("R3 turnaround write landed", 1'b1, shadow[14]);
  endtask

  logic done = 1'b0;

  initial begin
    for (int i = 0; i < (1 << AW); i++) shadow[i] = '0;
    t_reset();
    t_basic();
    t_commit();
    t_bypass();
    t_lanes();
    t_desel();
    t_oe();
    t_sleep();
    t_turn();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule